// File: doc/BRIEF.md
# Flash Aperture Chip-Select Window Decoder

This block splits one memory-mapped flash aperture among up to five chip selects. Each chip select owns a segment register. The register describes its window as a first 1 MB block and a last 1 MB block, and the last block is inclusive. A write port loads these registers. The lookup port accepts an aperture address and answers one clock later. The answer gives the chip select that owns the address, a hit or decode-error indication, an overlap flag, and the byte offset of the address inside the selected flash.

The window compare works on the block number, which is the address bits above the 1 MB boundary. An address belongs to a window when its block number lies between the first and last fields, both included. A last field of zero switches the window off. When several windows claim the same address, the lowest-numbered chip select wins and the overlap flag is raised. The offset is the aperture address minus the window's first byte.

Top module: `flash_window_decoder`

## Requirements
- R1: After reset all segment registers are zero and every response output is zero; a lookup made straight after reset returns a decode error.
- R2: A write with `cfg_we` high and `cfg_sel` below NUM_CS loads segment register `cfg_sel` at the clock edge. A write whose `cfg_sel` is NUM_CS or above changes no register.
- R3: Bits [11:4] of the written word set the first block, and bits [27:20] set the last block, of that window. An address with block number `req_addr[27:20]` hits chip select n when first_n <= block <= last_n. On a hit, `rsp_cs` has only bit n set and `rsp_hit` is 1.
- R4: A window whose last field is zero decodes no address, whatever its first field holds.
- R5: A lookup that hits no window gives `rsp_err` = 1, `rsp_hit` = 0, `rsp_cs` = 0 and `rsp_offset` = 0.
- R6: When more than one window matches, `rsp_cs` selects the lowest-numbered matching chip select and `rsp_overlap` is 1. Otherwise `rsp_overlap` is 0.
- R7: On a hit, `rsp_offset` equals `req_addr` minus (first block × 1 MB) of the selected window.
- R8: `rsp_valid` is high exactly one cycle after a cycle with `req_valid` high. While `rsp_valid` is low, `rsp_cs`, `rsp_hit`, `rsp_err`, `rsp_overlap` and `rsp_offset` are all zero.
- R9: A lookup made in the same cycle as a register write is decoded with the register contents from before that write.
- R10: Bits of the written word outside [11:4] and [27:20] have no effect on decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Segment register write strobe |
| cfg_sel | input | 3 | Chip select whose segment register is written |
| cfg_wdata | input | 32 | Segment register write word |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | 28 | Aperture byte address to decode |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_cs | output | 5 | One-hot selected chip select |
| rsp_hit | output | 1 | Address fell inside an enabled window |
| rsp_err | output | 1 | Address fell inside no window |
| rsp_overlap | output | 1 | More than one window matched |
| rsp_offset | output | 28 | Byte offset inside the selected flash |

## Verification
A register write and a lookup can land in the same cycle, and so can a lookup that matches a window and a write that is about to enable that window. The bench provokes the collision by placing a lookup into an unused window in the same cycle as a write that enables that window. It then expects a decode error. A second lookup after the write must report a hit with offset zero. Together the two results show that the decode reads the registers as they stood before the edge and picks up the new contents one cycle later.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
    // Segment register field layout (software writes these positions)
    localparam int SEG_REG_W     = 32;
    localparam int SEG_FIELD_W   = 8;
    localparam int SEG_FIRST_LSB = 4;
    localparam int SEG_LAST_LSB  = 20;

    typedef logic [SEG_FIELD_W-1:0] blk_t;

    typedef struct packed {
        blk_t first;
        blk_t last;
    } seg_t;
endpackage

// File: rtl/fwd_seg_regs.sv
module fwd_seg_regs
    import fwd_pkg::*;
#(
    parameter int NUM_CS = 5,
    localparam int SEL_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [SEL_W-1:0]      cfg_sel,
    input  logic [SEG_REG_W-1:0]  cfg_wdata,
    output seg_t [NUM_CS-1:0]     seg_o
);
    seg_t [NUM_CS-1:0] seg_d, seg_q;

    logic unused_wbits;
    assign unused_wbits = ^{cfg_wdata[SEG_FIRST_LSB-1:0],
                            cfg_wdata[SEG_LAST_LSB-1:SEG_FIRST_LSB+SEG_FIELD_W],
                            cfg_wdata[SEG_REG_W-1:SEG_LAST_LSB+SEG_FIELD_W]};

    always_comb begin
        seg_d = seg_q;
        for (int i = 0; i < NUM_CS; i++) begin
            if (cfg_we && (cfg_sel == SEL_W'(i))) begin
                seg_d[i].first = cfg_wdata[SEG_FIRST_LSB +: SEG_FIELD_W];
                seg_d[i].last  = cfg_wdata[SEG_LAST_LSB  +: SEG_FIELD_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seg_q <= '0;
        else        seg_q <= seg_d;
    end

    assign seg_o = seg_q;
endmodule

// File: rtl/fwd_window_match.sv
module fwd_window_match
    import fwd_pkg::*;
(
    input  blk_t blk_i,
    input  seg_t seg_i,
    output logic hit_o
);
    logic enabled;
    assign enabled = (seg_i.last != '0);
    assign hit_o   = enabled && (blk_i >= seg_i.first) && (blk_i <= seg_i.last);
endmodule

// File: rtl/fwd_lowest_pick.sv
module fwd_lowest_pick #(
    parameter int NUM_CS = 5,
    localparam int IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic [NUM_CS-1:0] req_i,
    output logic [NUM_CS-1:0] gnt_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic              any_o,
    output logic              multi_o
);
    always_comb begin
        gnt_o = '0;
        idx_o = '0;
        for (int i = NUM_CS - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                gnt_o    = '0;
                gnt_o[i] = 1'b1;
                idx_o    = IDX_W'(i);
            end
        end
    end

    assign any_o   = |req_i;
    assign multi_o = |(req_i & ~gnt_o);
endmodule

// File: rtl/flash_window_decoder.sv
module flash_window_decoder
    import fwd_pkg::*;
#(
    parameter int NUM_CS  = 5,
    parameter int BLK_LSB = 20,
    localparam int SEL_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
    localparam int ADDR_W = BLK_LSB + SEG_FIELD_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [SEL_W-1:0]     cfg_sel,
    input  logic [SEG_REG_W-1:0] cfg_wdata,
    input  logic                 req_valid,
    input  logic [ADDR_W-1:0]    req_addr,
    output logic                 rsp_valid,
    output logic [NUM_CS-1:0]    rsp_cs,
    output logic                 rsp_hit,
    output logic                 rsp_err,
    output logic                 rsp_overlap,
    output logic [ADDR_W-1:0]    rsp_offset
);
    typedef struct packed {
        logic              valid;
        logic [NUM_CS-1:0] cs;
        logic              hit;
        logic              err;
        logic              ovl;
        logic [ADDR_W-1:0] off;
    } rsp_t;

    seg_t [NUM_CS-1:0] seg;
    logic [NUM_CS-1:0] match;
    logic [NUM_CS-1:0] gnt;
    logic [SEL_W-1:0]  win_idx;
    logic              any_hit;
    logic              multi_hit;
    blk_t              blk;
    blk_t              sel_first;
    rsp_t              rsp_d, rsp_q;

    fwd_seg_regs #(.NUM_CS(NUM_CS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .seg_o     (seg)
    );

    assign blk = req_addr[ADDR_W-1:BLK_LSB];

    for (genvar g = 0; g < NUM_CS; g++) begin : g_win
        fwd_window_match u_match (
            .blk_i (blk),
            .seg_i (seg[g]),
            .hit_o (match[g])
        );
    end

    fwd_lowest_pick #(.NUM_CS(NUM_CS)) u_pick (
        .req_i   (match),
        .gnt_o   (gnt),
        .idx_o   (win_idx),
        .any_o   (any_hit),
        .multi_o (multi_hit)
    );

    assign sel_first = seg[win_idx].first;

    always_comb begin
        rsp_d       = '0;
        rsp_d.valid = req_valid;
        if (req_valid) begin
            rsp_d.hit = any_hit;
            rsp_d.err = !any_hit;
            rsp_d.ovl = multi_hit;
            rsp_d.cs  = gnt;
            if (any_hit)
                rsp_d.off = req_addr - {sel_first, {BLK_LSB{1'b0}}};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid   = rsp_q.valid;
    assign rsp_cs      = rsp_q.cs;
    assign rsp_hit     = rsp_q.hit;
    assign rsp_err     = rsp_q.err;
    assign rsp_overlap = rsp_q.ovl;
    assign rsp_offset  = rsp_q.off;
endmodule

// File: rtl/fwd_checker.sv
module fwd_checker #(
    parameter int NUM_CS = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              rsp_valid,
    input logic [NUM_CS-1:0] rsp_cs,
    input logic              rsp_hit,
    input logic              rsp_err,
    input logic              rsp_overlap
);
    // R8: a request is answered on the following cycle
    a_r8_answer_next: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R8: no request, no response
    a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R8: idle response outputs stay zero
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_cs == '0) && !rsp_hit && !rsp_err && !rsp_overlap);

    // R3/R6: at most one chip select granted
    a_r6_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rsp_cs));

    // R3: a hit drives exactly one chip select
    a_r3_hit_has_cs: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> ($countones(rsp_cs) == 1));

    // R5: a valid response is either a hit or a decode error
    a_r5_hit_xor_err: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_hit != rsp_err));

    // R6: overlap only flagged together with a hit
    a_r6_overlap_hit: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_overlap |-> rsp_hit);
endmodule

bind flash_window_decoder fwd_checker #(.NUM_CS(NUM_CS)) u_fwd_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .rsp_valid   (rsp_valid),
    .rsp_cs      (rsp_cs),
    .rsp_hit     (rsp_hit),
    .rsp_err     (rsp_err),
    .rsp_overlap (rsp_overlap)
);

// File: tb/test_flash_window_decoder.sv
module test_flash_window_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [27:0] req_addr = '0;
    logic        rsp_valid;
    logic [4:0]  rsp_cs;
    logic        rsp_hit, rsp_err, rsp_overlap;
    logic [27:0] rsp_offset;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    flash_window_decoder i_flash_window_decoder (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_cs(rsp_cs), .rsp_hit(rsp_hit),
        .rsp_err(rsp_err), .rsp_overlap(rsp_overlap), .rsp_offset(rsp_offset)
    );

    typedef struct packed {
        logic [27:0] addr;
        logic [4:0]  cs;
        logic        err;
        logic [27:0] off;
    } vec_t;

    // Windows: cs0 blocks 0..1, cs1 2..5, cs2 6..6, cs3 off, cs4 0x10..0x1F
    localparam vec_t VECS [11] = '{
        '{28'h0000000, 5'b00001, 1'b0, 28'h0000000}, // R3 R7 first byte
        '{28'h01FFFFF, 5'b00001, 1'b0, 28'h01FFFFF}, // R3 inclusive last block
        '{28'h0200000, 5'b00010, 1'b0, 28'h0000000}, // R3 boundary
        '{28'h05ABCDE, 5'b00010, 1'b0, 28'h03ABCDE}, // R7
        '{28'h0600010, 5'b00100, 1'b0, 28'h0000010}, // R10 junk bits written
        '{28'h0700000, 5'b00000, 1'b1, 28'h0000000}, // R4 disabled window
        '{28'h0FFFFFF, 5'b00000, 1'b1, 28'h0000000}, // R5 gap
        '{28'h1000000, 5'b10000, 1'b0, 28'h0000000}, // R3
        '{28'h1FFFFFF, 5'b10000, 1'b0, 28'h0FFFFFF}, // R7
        '{28'h2000000, 5'b00000, 1'b1, 28'h0000000}, // R5 above all
        '{28'hFFFFFFF, 5'b00000, 1'b1, 28'h0000000}  // R5 top of aperture
    };

    function automatic logic [63:0] pk(logic v, logic [4:0] cs, logic h,
                                       logic e, logic o, logic [27:0] off);
        return {27'b0, v, cs, h, e, o, off};
    endfunction

    function automatic logic [63:0] actual();
        return pk(rsp_valid, rsp_cs, rsp_hit, rsp_err, rsp_overlap, rsp_offset);
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] sel, logic [7:0] first, logic [7:0] last, bit junk);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_sel   = sel;
        cfg_wdata = {4'b0, last, 8'b0, first, 4'b0} | (junk ? 32'hF00FF00F : 32'h0);
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic look(logic [27:0] a);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        #200000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 outputs in reset", actual(), '0);
        rst_n = 1'b1;
        look(28'h0000000);
        check("R1 lookup after reset", actual(), pk(1, 0, 0, 1, 0, 0));
        @(negedge clk);
        check("R8 idle outputs", actual(), '0);

        wr(3'd0, 8'h00, 8'h01, 0);
        wr(3'd1, 8'h02, 8'h05, 0);
        wr(3'd2, 8'h06, 8'h06, 1);   // R10 junk outside fields
        wr(3'd3, 8'h07, 8'h00, 0);   // R4 last field zero
        wr(3'd4, 8'h10, 8'h1F, 0);

        foreach (VECS[i]) begin
            look(VECS[i].addr);
            check($sformatf("R3/R5/R7 vector %0d", i), actual(),
                  pk(1, VECS[i].cs, !VECS[i].err, VECS[i].err, 0, VECS[i].off));
        end

        // R2: out-of-range selects must not load anything
        wr(3'd5, 8'h00, 8'hFF, 0);
        wr(3'd7, 8'h00, 8'hFF, 0);
        look(28'h0700000);
        check("R2 out-of-range select ignored", actual(), pk(1, 0, 0, 1, 0, 0));
        look(28'h3000000);
        check("R2 out-of-range select ignored high", actual(), pk(1, 0, 0, 1, 0, 0));

        // R9: write and lookup in the same cycle
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 3'd3; cfg_wdata = {4'b0, 8'h07, 8'b0, 8'h07, 4'b0};
        req_valid = 1'b1; req_addr = 28'h0700000;
        @(negedge clk);
        cfg_we = 1'b0; req_valid = 1'b0;
        check("R9 same-cycle lookup sees old contents", actual(), pk(1, 0, 0, 1, 0, 0));
        look(28'h0700000);
        check("R9 next lookup sees new contents", actual(), pk(1, 5'b01000, 1, 0, 0, 0));

        // R6: overlap, lowest index wins
        wr(3'd1, 8'h00, 8'h05, 0);
        look(28'h0100000);
        check("R6 overlap picks lowest", actual(), pk(1, 5'b00001, 1, 0, 1, 28'h0100000));
        look(28'h0300000);
        check("R6 single match no flag", actual(), pk(1, 5'b00010, 1, 0, 0, 28'h0300000));
        @(negedge clk);
        check("R8 idle after lookups", actual(), '0);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule